// File: doc/BRIEF.md
# Playback Status Pin Generator

This block turns the start and end events of a voice playback into two status pins for the outside world. Three kinds of status signal are produced. BUSY is a level that is high while a group plays. STOP is a fixed-width pulse that is issued when a group finishes. LED_A and LED_B are two anti-phase flash signals that blink during playback. A 2-bit whole-chip option code selects which of these signals drives each pin.

All timing is counted in sample ticks, which arrive as a one-cycle strobe, so pulse widths and flash rates scale with the sampling rate. At 8 kHz sampling the defaults give a STOP pulse of 64 ms (512 ticks) and a flash period of about 3 Hz (toggle every 1333 ticks). The block takes a per-group STOP enable. That bit is captured when playback starts, so each group decides for itself whether its end produces a pulse. Every input is a plain control strobe or level, and every output is a plain status level.

Top module: `play_status_out`

## Requirements
- R1: While `rst_n` is low, both pins are low for every option code, and all counters and state are cleared.
- R2: BUSY is high from the cycle after a `play_start` pulse until the cycle after a `play_end` pulse.
- R3: `opt_map` assigns (`pin_a`, `pin_b`) as follows: 2'b00 gives (LED_B, LED_A); 2'b01 gives (LED_B, STOP); 2'b10 gives (LED_B, BUSY); 2'b11 gives (STOP, BUSY).
- R4: STOP fires only if `stop_en` was high in the `play_start` cycle of the group that ends. `stop_en` has no effect in any other cycle.
- R5: When `play_end` arrives during playback with STOP enabled, STOP rises in the next cycle. It stays high until `STOP_TICKS` ticks have been counted, and falls in the cycle after the last of those ticks.
- R6: A `play_end` pulse while idle is ignored: no STOP pulse and no BUSY change.
- R7: Both LEDs are low when idle. At start, LED_A is low and LED_B is high. The two LEDs swap after every `LED_HALF` ticks of playback.
- R8: A `play_start` during a STOP pulse ends that pulse in the next cycle.
- R9: When `play_start` and `play_end` arrive in the same cycle, the start wins: playback continues and no STOP pulse is issued.
- R10: Ticks while idle with no STOP pulse pending change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sample tick strobe |
| play_start | input | 1 | One-cycle pulse, playback begins |
| play_end | input | 1 | One-cycle pulse, playback finished |
| stop_en | input | 1 | STOP enable of the starting group, sampled with `play_start` |
| opt_map | input | 2 | Whole-chip pin assignment code |
| pin_a | output | 1 | First status pin |
| pin_b | output | 1 | Second status pin |

## Verification
The bench counts ticks exactly at the edges of the STOP pulse: it checks that the pulse is still high after `STOP_TICKS`-1 ticks and low after the last one. A counter that is off by one would stretch or shorten the pulse and fail there. The bench also raises `stop_en` only in the end cycle, which catches a design that samples the enable late. It fires start and end in the same cycle, and a design that gives the end priority would drop BUSY and emit a spurious STOP. Finally, it restarts playback during a live STOP pulse, where a design that keeps the old pulse would show STOP and BUSY together on the same option.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic [1:0] {
    MAP_LED_LED   = 2'd0,
    MAP_LED_STOP  = 2'd1,
    MAP_LED_BUSY  = 2'd2,
    MAP_STOP_BUSY = 2'd3
  } pin_map_e;

  typedef struct packed {
    logic busy;
    logic stop;
    logic led_a;
    logic led_b;
  } status_t;
endpackage

// File: rtl/psg_play_state.sv
module psg_play_state (
  input  logic clk,
  input  logic rst_n,
  input  logic play_start,
  input  logic play_end,
  input  logic stop_en,
  output logic busy,
  output logic stop_fire
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      en_q <= 1'b0;
    end else if (play_start) begin
      busy <= 1'b1;
      en_q <= stop_en;
    end else if (play_end) begin
      busy <= 1'b0;
    end
  end

  // an end that is not overridden by a simultaneous start, during playback
  assign stop_fire = play_end & ~play_start & busy & en_q;
endmodule

// File: rtl/psg_stop_pulse.sv
module psg_stop_pulse #(
  parameter int STOP_TICKS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  input  logic cancel,
  output logic active
);
  localparam int CW = $clog2(STOP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STOP_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (cancel) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psg_led_flash.sv
module psg_led_flash #(
  parameter int LED_HALF = 1333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic busy,
  output logic led_a,
  output logic led_b
);
  localparam int CW = $clog2(LED_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(LED_HALF - 1);

  logic [CW-1:0] cnt;
  logic          phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart || !busy) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign led_a = busy & phase;
  assign led_b = busy & ~phase;
endmodule

// File: rtl/psg_pin_mux.sv
module psg_pin_mux
  import psg_pkg::*;
(
  input  pin_map_e sel,
  input  status_t  st,
  output logic     pin_a,
  output logic     pin_b
);
  always_comb begin
    unique case (sel)
      MAP_LED_LED:   begin pin_a = st.led_b; pin_b = st.led_a; end
      MAP_LED_STOP:  begin pin_a = st.led_b; pin_b = st.stop;  end
      MAP_LED_BUSY:  begin pin_a = st.led_b; pin_b = st.busy;  end
      default:       begin pin_a = st.stop;  pin_b = st.busy;  end
    endcase
  end
endmodule

// File: rtl/play_status_out.sv
module play_status_out
  import psg_pkg::*;
#(
  parameter int STOP_TICKS = 512,
  parameter int LED_HALF   = 1333
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       play_start,
  input  logic       play_end,
  input  logic       stop_en,
  input  logic [1:0] opt_map,
  output logic       pin_a,
  output logic       pin_b
);
  logic    busy_q;
  logic    stop_fire;
  logic    stop_act;
  logic    led_a;
  logic    led_b;
  status_t st;

  psg_play_state u_state (
    .clk(clk), .rst_n(rst_n), .play_start(play_start), .play_end(play_end),
    .stop_en(stop_en), .busy(busy_q), .stop_fire(stop_fire)
  );

  psg_stop_pulse #(.STOP_TICKS(STOP_TICKS)) u_stop (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fire(stop_fire),
    .cancel(play_start), .active(stop_act)
  );

  psg_led_flash #(.LED_HALF(LED_HALF)) u_led (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(play_start),
    .busy(busy_q), .led_a(led_a), .led_b(led_b)
  );

  assign st = '{busy: busy_q, stop: stop_act, led_a: led_a, led_b: led_b};

  psg_pin_mux u_mux (
    .sel(pin_map_e'(opt_map)), .st(st), .pin_a(pin_a), .pin_b(pin_b)
  );
endmodule

// File: rtl/psg_chk.sv
module psg_chk #(
  parameter int STOP_TICKS = 512
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic play_start,
  input logic play_end,
  input logic busy,
  input logic stop_act,
  input logic led_a,
  input logic led_b
);
  localparam int CW = $clog2(STOP_TICKS + 2);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!stop_act) seen <= '0;
    else if (tick) seen <= seen + 1'b1;
  end

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |=> busy);

  // R5
  stop_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_act) |-> ($past(play_end) && $past(busy)));

  // R9
  start_blocks_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |=> !stop_act);

  // R7
  led_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!led_a && !led_b));

  // R7
  led_antiphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (led_a != led_b));

  // R5
  stop_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_act |-> (seen < CW'(STOP_TICKS)));
endmodule

bind play_status_out psg_chk #(.STOP_TICKS(STOP_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .play_start(play_start),
  .play_end(play_end), .busy(busy_q), .stop_act(stop_act),
  .led_a(led_a), .led_b(led_b)
);

// File: tb/play_status_out_test.sv
module play_status_out_test;
  localparam int STOPT = 8;
  localparam int HALF  = 5;

  typedef struct {
    bit    a;
    bit    b;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       play_start = 1'b0;
  logic       play_end = 1'b0;
  logic       stop_en = 1'b0;
  logic [1:0] opt_map = 2'd0;
  logic       pin_a, pin_b;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  play_status_out #(.STOP_TICKS(STOPT), .LED_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .play_start(play_start),
    .play_end(play_end), .stop_en(stop_en), .opt_map(opt_map),
    .pin_a(pin_a), .pin_b(pin_b)
  );

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (pin_a !== e.a || pin_b !== e.b) begin
        n_fail++;
        $display("FAIL %s: pins=%b%b expected=%b%b", e.tag, pin_a, pin_b, e.a, e.b);
      end
    end
  end

  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_pins(bit a, bit b, string tag);
    exp_t e;
    e.a = a; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_start(bit en);
    play_start = 1'b1; stop_en = en;
    clk1();
    play_start = 1'b0; stop_en = 1'b0;
  endtask

  task automatic do_end();
    play_end = 1'b1;
    clk1();
    play_end = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    clk1();
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state on every option code
    for (int k = 0; k < 4; k++) begin
      opt_map = 2'(k);
      expect_pins(1'b0, 1'b0, "R1");
      clk1();
    end
    rst_n = 1'b1;
    clk1();

    // R2 / R5: option 3 = (STOP, BUSY)
    opt_map = 2'd3;
    do_start(1'b1);
    expect_pins(1'b0, 1'b1, "R2");
    clk1();
    for (int k = 0; k < 3; k++) begin
      one_tick();
      expect_pins(1'b0, 1'b1, "R2");
      clk1();
    end
    do_end();
    expect_pins(1'b1, 1'b0, "R5");
    clk1();
    for (int k = 1; k < STOPT; k++) begin
      one_tick();
      expect_pins(1'b1, 1'b0, "R5");
      clk1();
    end
    one_tick();
    expect_pins(1'b0, 1'b0, "R5");
    clk1();

    // R6 / R10: end and ticks while idle
    do_end();
    expect_pins(1'b0, 1'b0, "R6");
    clk1();
    one_tick();
    expect_pins(1'b0, 1'b0, "R10");
    clk1();

    // R4: enable only sampled at start
    do_start(1'b0);
    expect_pins(1'b0, 1'b1, "R4");
    play_end = 1'b1; stop_en = 1'b1;
    clk1();
    play_end = 1'b0; stop_en = 1'b0;
    expect_pins(1'b0, 1'b0, "R4");
    clk1();

    // R7: option 0 = (LED_B, LED_A)
    opt_map = 2'd0;
    expect_pins(1'b0, 1'b0, "R7");
    clk1();
    do_start(1'b0);
    expect_pins(1'b1, 1'b0, "R7");
    clk1();
    for (int k = 1; k < HALF; k++) begin
      one_tick();
      expect_pins(1'b1, 1'b0, "R7");
      clk1();
    end
    one_tick();
    expect_pins(1'b0, 1'b1, "R7");
    clk1();
    for (int k = 1; k < HALF; k++) begin
      one_tick();
      expect_pins(1'b0, 1'b1, "R7");
      clk1();
    end
    one_tick();
    expect_pins(1'b1, 1'b0, "R7");
    clk1();
    do_end();
    expect_pins(1'b0, 1'b0, "R7");
    clk1();

    // R3: option 1 = (LED_B, STOP), option 2 = (LED_B, BUSY)
    opt_map = 2'd1;
    do_start(1'b1);
    expect_pins(1'b1, 1'b0, "R3");
    clk1();
    do_end();
    expect_pins(1'b0, 1'b1, "R3");
    clk1();
    opt_map = 2'd2;
    expect_pins(1'b0, 1'b0, "R3");
    clk1();
    // R8: restart during the live STOP pulse
    do_start(1'b0);
    expect_pins(1'b1, 1'b1, "R3");
    clk1();
    opt_map = 2'd3;
    expect_pins(1'b0, 1'b1, "R8");
    clk1();
    do_end();
    expect_pins(1'b0, 1'b0, "R8");
    clk1();

    // R9: start and end in the same cycle
    do_start(1'b1);
    expect_pins(1'b0, 1'b1, "R9");
    play_start = 1'b1; play_end = 1'b1; stop_en = 1'b1;
    clk1();
    play_start = 1'b0; play_end = 1'b0; stop_en = 1'b0;
    expect_pins(1'b0, 1'b1, "R9");
    clk1();
    do_end();
    expect_pins(1'b1, 1'b0, "R9");
    clk1();
    for (int k = 0; k < STOPT; k++) one_tick();
    expect_pins(1'b0, 1'b0, "R5");
    clk1();
    clk1();

    done = 1'b1;
    finish_run();
  end
endmodule